// File: doc/BRIEF.md
# Interrupt Status, Mask and Bus-Control Register Bank

The block holds the pending and enable state of a small interrupt controller, plus a handful of bus-control registers, behind one 32-bit register write port and one 32-bit read port. Peripheral event pulses arrive on a source vector. Each pulse latches a pending bit. A registered request line goes high whenever a pending bit meets its enable.

Every register has its own write rule, and software uses each rule differently. The pending register is cleared by writing ones to it. The enable register is flipped bit by bit, so a driver can change one enable without reading the register first. A flag register accumulates ones, and a second flag register only loses ones. A command register accepts any value but never keeps its busy flag set, which means a poll of that flag completes at once.

Registers are word addressed: pending = 0, enable = 1, OR-flag = 2, ANDN-flag = 3, command = 4. Writes to any other address are dropped, and reads from them return zero.

Top module: `irq_reg_bank`

## Requirements
- R1: A 1 on source bit i in a cycle makes pending bit i read as 1 from the next clock edge onward, until it is cleared.
- R2: A write to address 1 XORs bits 15:0 of the write data into the 16-bit enable register. Bits 31:16 of the data have no effect.
- R3: A write to address 0 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value.
- R4: `irq_o` is a register that, from each clock edge, equals the OR over all sources of (pending AND enable). A write to the enable or pending register is therefore reflected on `irq_o` at the same edge that updates the register.
- R5: When a source pulse and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R6: A write to address 2 ORs the data into the OR-flag register, whose reset value is 0x00000000.
- R7: A write to address 3 ANDs the ANDN-flag register with the complement of the data. Its reset value is 0xFFFFFFFF.
- R8: A write to address 4 stores the data in the command register with bit 31 (busy) forced to 0.
- R9: A write to an address above 4 changes no register, and a read from such an address returns 0.
- R10: Enable bits at and above NUM_SRC can be toggled and read back but never raise `irq_o`. Pending bits at and above NUM_SRC read as 0.
- R11: After reset, pending, enable, OR-flag and command read 0, ANDN-flag reads 0xFFFFFFFF, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Word address of the write |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Word address of the read |
| rd_data_o | output | DATA_W | Read data, combinational from the address |
| src_i | input | NUM_SRC | Interrupt source pulses |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the bank with NUM_SRC = 12, ADDR_W = 3 and DATA_W = 32. With fewer sources than the 16 enable bits, the upper enable bits exist with no pending bit behind them. Setting those bits without any request appearing exercises the width boundary. The 3-bit address reaches the three unused word addresses 5 to 7, so dropped writes and zero reads are checked at the ports. The same-cycle pulse and clear is driven on a bit that is already pending and enabled.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int unsigned MASK_W   = 16;
  localparam int unsigned REG_STAT = 0;
  localparam int unsigned REG_MASK = 1;
  localparam int unsigned REG_SET  = 2;
  localparam int unsigned REG_CLR  = 3;
  localparam int unsigned REG_CMD  = 4;
  localparam int unsigned NUM_REGS = 5;

  typedef enum logic [1:0] {
    BOP_OR   = 2'd0,
    BOP_ANDN = 2'd1,
    BOP_CMD  = 2'd2
  } bop_e;
endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned NUM_REGS = 5
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic [NUM_REGS-1:0] we_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign we_o[g] = wr_en_i && (wr_addr_i == ADDR_W'(g));
  end

  always_comb begin
    assert ($onehot0(we_o)) else $error("a_r9_onehot_we");
  end
endmodule

// File: rtl/irq_stat_mask.sv
module irq_stat_mask
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stat_we_i,
  input  logic               mask_we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic [MASK_W-1:0]  mask_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] stat_q, stat_d, clr_bits;
  logic [MASK_W-1:0]  mask_q, mask_d;
  logic               irq_q, irq_d;

  // source set wins over a same-cycle clear
  always_comb begin
    clr_bits = stat_we_i ? wdata_i[NUM_SRC-1:0] : '0;
    stat_d   = (stat_q & ~clr_bits) | src_i;
    mask_d   = mask_we_i ? (mask_q ^ wdata_i[MASK_W-1:0]) : mask_q;
    irq_d    = |(stat_d & mask_d[NUM_SRC-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq_q  <= irq_d;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  a_r1_src_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> ((stat_q & $past(src_i)) == $past(src_i)));
  a_r2_mask_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_q == ($past(mask_q) ^ $past(wdata_i[MASK_W-1:0]))));
  a_r2_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));
  a_r3_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && src_i == '0) |=>
      (stat_q == ($past(stat_q) & ~$past(wdata_i[NUM_SRC-1:0]))));
  a_r4_irq_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(stat_o & mask_o[NUM_SRC-1:0]));
endmodule

// File: rtl/irq_bitop_reg.sv
module irq_bitop_reg
  import irq_bank_pkg::*;
#(
  parameter bop_e                MODE    = BOP_OR,
  parameter int unsigned         DATA_W  = 32,
  parameter logic [DATA_W-1:0]   RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  localparam int unsigned BUSY_BIT = DATA_W - 1;

  logic [DATA_W-1:0] q, d;

  if (MODE == BOP_OR) begin : g_or
    assign d = q | wdata_i;
  end else if (MODE == BOP_ANDN) begin : g_andn
    assign d = q & ~wdata_i;
  end else begin : g_cmd
    assign d = {1'b0, wdata_i[BUSY_BIT-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= RST_VAL;
    else if (we_i) q <= d;
  end

  assign q_o = q;

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));

  if (MODE == BOP_OR) begin : g_a_or
    a_r6_or_accum: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> (q_o == ($past(q_o) | $past(wdata_i))));
  end else if (MODE == BOP_ANDN) begin : g_a_andn
    a_r7_andn_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> (q_o == ($past(q_o) & ~$past(wdata_i))));
  end else begin : g_a_cmd
    a_r8_busy_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !q_o[BUSY_BIT]);
    a_r8_cmd_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> (q_o[BUSY_BIT-1:0] == $past(wdata_i[BUSY_BIT-1:0])));
  end
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);
  logic [NUM_REGS-1:0] we;
  logic [NUM_SRC-1:0]  stat;
  logic [MASK_W-1:0]   mask;
  logic [DATA_W-1:0]   set_q, clr_q, cmd_q;

  irq_wr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .we_o     (we)
  );

  irq_stat_mask #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stat_we_i(we[REG_STAT]),
    .mask_we_i(we[REG_MASK]),
    .wdata_i  (wr_data_i),
    .src_i    (src_i),
    .stat_o   (stat),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  irq_bitop_reg #(.MODE(BOP_OR), .DATA_W(DATA_W), .RST_VAL('0)) u_set (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we[REG_SET]),
    .wdata_i(wr_data_i), .q_o(set_q)
  );

  irq_bitop_reg #(.MODE(BOP_ANDN), .DATA_W(DATA_W), .RST_VAL('1)) u_clr (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we[REG_CLR]),
    .wdata_i(wr_data_i), .q_o(clr_q)
  );

  irq_bitop_reg #(.MODE(BOP_CMD), .DATA_W(DATA_W), .RST_VAL('0)) u_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we[REG_CMD]),
    .wdata_i(wr_data_i), .q_o(cmd_q)
  );

  always_comb begin
    rd_data_o = '0;
    if      (rd_addr_i == ADDR_W'(REG_STAT)) rd_data_o = DATA_W'(stat);
    else if (rd_addr_i == ADDR_W'(REG_MASK)) rd_data_o = DATA_W'(mask);
    else if (rd_addr_i == ADDR_W'(REG_SET))  rd_data_o = set_q;
    else if (rd_addr_i == ADDR_W'(REG_CLR))  rd_data_o = clr_q;
    else if (rd_addr_i == ADDR_W'(REG_CMD))  rd_data_o = cmd_q;
  end

  a_r10_upper_mask_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat == '0) |-> !irq_o);
endmodule

// File: tb/irq_reg_bank_tb.sv
module irq_reg_bank_tb;
  localparam int unsigned NS = 12;
  localparam int unsigned AW = 3;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [NS-1:0] src = '0;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  irq_reg_bank #(.NUM_SRC(NS), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .src_i(src), .irq_o(irq)
  );

  task automatic chk_reg(input int addr, input logic [DW-1:0] exp, input string req);
    rd_addr = AW'(addr);
    #1;
    n_chk++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s addr %0d: got %h expected %h", req, addr, rd_data, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string req);
    n_chk++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL %s irq: got %b expected %b", req, irq, exp);
    end
  endtask

  // one cycle with optional write and source pulse; returns at the following negedge
  task automatic cyc(input logic we, input int addr, input logic [DW-1:0] d,
                     input logic [NS-1:0] s);
    @(negedge clk);
    wr_en = we; wr_addr = AW'(addr); wr_data = d; src = s;
    @(negedge clk);
    wr_en = 1'b0; src = '0;
  endtask

  task automatic t_reset;
    chk_reg(0, 32'h0, "R11");
    chk_reg(1, 32'h0, "R11");
    chk_reg(2, 32'h0, "R11");
    chk_reg(3, 32'hFFFF_FFFF, "R11");
    chk_reg(4, 32'h0, "R11");
    chk_irq(1'b0, "R11");
  endtask

  task automatic t_src_latch;
    cyc(1'b0, 0, '0, 12'h008);
    chk_reg(0, 32'h8, "R1");
    chk_irq(1'b0, "R1");
    cyc(1'b0, 0, '0, '0);
    chk_reg(0, 32'h8, "R1");
  endtask

  task automatic t_mask_toggle;
    cyc(1'b1, 1, 32'h0008_0009, '0);
    chk_reg(1, 32'h9, "R2");
    chk_irq(1'b1, "R4");
    cyc(1'b1, 1, 32'h0000_0001, '0);
    chk_reg(1, 32'h8, "R2");
    chk_irq(1'b1, "R4");
    cyc(1'b1, 1, 32'h0000_0008, '0);
    chk_reg(1, 32'h0, "R2");
    chk_irq(1'b0, "R4");
  endtask

  task automatic t_w1c;
    cyc(1'b0, 0, '0, 12'h0A0);
    chk_reg(0, 32'hA8, "R1");
    cyc(1'b1, 0, 32'hFFFF_0028, '0);
    chk_reg(0, 32'h80, "R3");
  endtask

  task automatic t_priority;
    cyc(1'b1, 1, 32'h80, '0);
    chk_irq(1'b1, "R4");
    cyc(1'b1, 0, 32'h80, 12'h080);
    chk_reg(0, 32'h80, "R5");
    chk_irq(1'b1, "R5");
    cyc(1'b1, 0, 32'h80, '0);
    chk_reg(0, 32'h0, "R3");
    chk_irq(1'b0, "R4");
  endtask

  task automatic t_flags;
    cyc(1'b1, 2, 32'h0F0, '0);
    cyc(1'b1, 2, 32'h300, '0);
    chk_reg(2, 32'h3F0, "R6");
    cyc(1'b1, 3, 32'h0000_FFFF, '0);
    chk_reg(3, 32'hFFFF_0000, "R7");
    cyc(1'b1, 3, 32'h00F0_0000, '0);
    chk_reg(3, 32'hFF0F_0000, "R7");
  endtask

  task automatic t_cmd;
    cyc(1'b1, 4, 32'hDEAD_BEEF, '0);
    chk_reg(4, 32'h5EAD_BEEF, "R8");
    cyc(1'b1, 4, 32'h1234_5678, '0);
    chk_reg(4, 32'h1234_5678, "R8");
  endtask

  task automatic t_unmapped;
    for (int a = 5; a < 8; a++) begin
      cyc(1'b1, a, 32'hFFFF_FFFF, '0);
      chk_reg(a, 32'h0, "R9");
    end
    chk_reg(0, 32'h0, "R9");
    chk_reg(1, 32'h80, "R9");
    chk_reg(2, 32'h3F0, "R9");
    chk_reg(3, 32'hFF0F_0000, "R9");
    chk_reg(4, 32'h1234_5678, "R9");
  endtask

  task automatic t_width_edge;
    cyc(1'b1, 1, 32'h0000_F080, '0);
    chk_reg(1, 32'hF000, "R10");
    cyc(1'b0, 0, '0, 12'h001);
    chk_reg(0, 32'h1, "R10");
    chk_irq(1'b0, "R10");
    cyc(1'b1, 0, 32'hFFFF_FFFF, '0);
    chk_reg(0, 32'h0, "R10");
  endtask

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_src_latch;
    t_mask_toggle;
    t_w1c;
    t_priority;
    t_flags;
    t_cmd;
    t_unmapped;
    t_width_edge;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule